// File: doc/BRIEF.md
# Fixed-OR Programmable Logic Array with Pin Feedback

This block is a configurable sum-of-products array. A programmable AND plane forms product terms from ten dedicated inputs and from six pins that loop back into the array. Each of the eight output pins owns a private group of seven product terms. These terms feed a fixed OR gate, and the OR result is inverted before it reaches the pin. An eighth product term per pin drives that pin's three-state enable. When a loop-back pin has its enable off, the array reads the externally driven pin value instead, so that pin serves as an extra input.

The connection map is 2048 bits. It is loaded serially, one bit per rising edge of `cfg_clk`, while `cfg_load` is high. While loading is in progress every pin enable is held low. The array itself is purely combinational. Outputs follow the inputs within the same cycle once the map is in place. Configurations that form a combinational loop through the loop-back pins are not supported.

Top module: `fixed_or_array`

## Requirements
- R1: For each pin k (0..7), `pin_out[k]` is the complement of the OR of its seven logic terms (term numbers 0..6). No term is shared between pins.
- R2: A product term is the AND of the literals connected to it. A term with no literal connected evaluates to 1, so a pin whose seven logic terms are all empty drives `pin_out` low.
- R3: A term that has both the true and the complement literal of the same signal connected evaluates to 0. A pin whose seven logic terms are all like this drives `pin_out` high.
- R4: When `cfg_load` is low, `pin_oe[k]` equals the value of term number 7 of pin k.
- R5: Pins 1..6 loop back as array signals 10..15, with pin j feeding signal 9+j. The value fed back is `pin_out[j]` when `pin_oe[j]` is 1, and `pin_in[j]` otherwise. Signals 0..9 are `in_pins[0..9]`.
- R6: Pins 0 and 7 have no loop-back, so `pin_in[0]` and `pin_in[7]` have no effect on any output.
- R7: Map bit index = (pin*8 + term)*32 + 2*signal + c. Here c=0 selects the true literal and c=1 the complement, and a 1 means the literal is connected.
- R8: While `cfg_load` is high, each rising `cfg_clk` edge shifts in `cfg_din`. After 2048 shifts, the first bit shifted in sits at map index 0. While `cfg_load` is low, the map holds its contents.
- R9: While `cfg_load` is high, every `pin_oe` bit is 0, starting in the same cycle `cfg_load` rises.
- R10: A synchronous active-low reset sets every map bit to 1. After reset, `pin_out` is all ones and `pin_oe` is all zeros for any input.
- R11: Loop-back chains through up to six pins, in any pin order, settle to the acyclic result within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Synchronous active-low reset of the map |
| cfg_load | input | 1 | High while the map is being shifted in |
| cfg_din | input | 1 | Serial map data |
| in_pins | input | 10 | Dedicated array inputs, signals 0..9 |
| pin_in | input | 8 | Value seen on each pin when it is not driven |
| pin_out | output | 8 | Value each pin drives (inverted OR) |
| pin_oe | output | 8 | Three-state enable of each pin |

## Verification
Pin values and enables are combinational. They are due in the same cycle as the input change, including after a chain of loop-back pins. The bench therefore changes `in_pins` and `pin_in` on the falling edge and compares one time unit later, well before the next rising edge. A new map takes effect at the rising edge that shifts its final bit. The bench drives map bits on falling edges and lowers `cfg_load` at the next falling edge, then starts comparing. The enable blanking during a load is checked one time unit after `cfg_load` rises, because it must not wait for a clock.

// File: rtl/far_pkg.sv
// Shared constants and index helpers for the fixed-OR array.
// Assumes: literal columns interleave true/complement per signal.
package far_pkg;

    localparam int unsigned DEF_N_IN  = 10;
    localparam int unsigned DEF_N_PIN = 8;
    localparam int unsigned DEF_N_OR  = 7;
    localparam int unsigned DEF_FB_LO = 1;
    localparam int unsigned DEF_FB_HI = 6;

    // Column of a literal inside one product term's fuse row.
    function automatic int unsigned col_of(input int unsigned sig, input bit neg);
        return 2 * sig + (neg ? 1 : 0);
    endfunction

    // Evaluation passes needed so an acyclic loop-back chain settles.
    function automatic int unsigned settle_stages(input int unsigned n_fb);
        return n_fb + 1;
    endfunction

endpackage

// File: rtl/far_fuse_chain.sv
// Serial connection-map store: a shift register loaded one bit per
// clock while enabled. Assumes: MAP_BITS >= 2. Reset fills with ones.
module far_fuse_chain #(
    parameter int unsigned MAP_BITS = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                din,
    output logic [MAP_BITS-1:0] map_q
);

    // Reset to all-connected, else shift new bit in at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '1;
        end else if (shift_en) begin
            map_q <= {din, map_q[MAP_BITS-1:1]};
        end
    end

endmodule

// File: rtl/far_pterm.sv
// One product term of the AND plane. Assumes: fuse row holds a true
// and a complement column per signal, as laid out by far_pkg::col_of.
module far_pterm #(
    parameter int unsigned N_SIG = 16
) (
    input  logic [N_SIG-1:0]   sig,
    input  logic [2*N_SIG-1:0] fuse,
    output logic               term
);

    logic [N_SIG-1:0] use_t;
    logic [N_SIG-1:0] use_c;

    // Split the fuse row into true and complement connection masks.
    for (genvar s = 0; s < N_SIG; s++) begin : g_split
        assign use_t[s] = fuse[far_pkg::col_of(s, 1'b0)];
        assign use_c[s] = fuse[far_pkg::col_of(s, 1'b1)];
    end

    // AND of connected literals; unconnected literals count as 1.
    always_comb begin
        term = &((~use_t | sig) & (~use_c | ~sig));
        if (|(use_t & use_c)) begin
            assert_contra_zero_R3: assert (term == 1'b0);
        end
    end

endmodule

// File: rtl/far_macrocell.sv
// Output cell: a private group of logic terms into a fixed, inverted
// OR, plus one extra term for the pin enable. Assumes: enable term is
// the last row of the cell's fuse slice.
module far_macrocell #(
    parameter int unsigned N_SIG = 16,
    parameter int unsigned N_OR  = 7
) (
    input  logic [N_SIG-1:0]                 sig,
    input  logic [(N_OR+1)*2*N_SIG-1:0]      fuse,
    output logic                             drive,
    output logic                             en
);

    localparam int unsigned N_COL = 2 * N_SIG;

    logic [N_OR:0] terms;

    // One product term per fuse row, enable term included.
    for (genvar t = 0; t <= N_OR; t++) begin : g_term
        far_pterm #(.N_SIG(N_SIG)) u_pterm (
            .sig  (sig),
            .fuse (fuse[t*N_COL +: N_COL]),
            .term (terms[t])
        );
    end

    // Fixed OR of the logic terms, inverted onto the pin.
    assign drive = ~(|terms[N_OR-1:0]);
    // Dedicated enable term.
    assign en    = terms[N_OR];

endmodule

// File: rtl/far_stage.sv
// One full evaluation pass of the array: all pins computed from the
// inputs and a given loop-back vector, then the next loop-back vector.
// Assumes: loop-back pins are the contiguous range FB_LO..FB_HI.
module far_stage #(
    parameter int unsigned N_IN  = 10,
    parameter int unsigned N_PIN = 8,
    parameter int unsigned N_OR  = 7,
    parameter int unsigned FB_LO = 1,
    parameter int unsigned FB_HI = 6,
    localparam int unsigned N_FB     = FB_HI - FB_LO + 1,
    localparam int unsigned N_SIG    = N_IN + N_FB,
    localparam int unsigned PIN_BITS = (N_OR + 1) * 2 * N_SIG,
    localparam int unsigned MAP_BITS = N_PIN * PIN_BITS
) (
    input  logic [N_IN-1:0]     in_pins,
    input  logic [N_FB-1:0]     fb_ext,
    input  logic [N_FB-1:0]     fb_in,
    input  logic [MAP_BITS-1:0] map,
    output logic [N_PIN-1:0]    drive,
    output logic [N_PIN-1:0]    en,
    output logic [N_FB-1:0]     fb_out
);

    logic [N_SIG-1:0] sig;

    // Array signal order: dedicated inputs low, loop-back pins above.
    assign sig = {fb_in, in_pins};

    // One output cell per pin, each on its own fuse slice.
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        far_macrocell #(.N_SIG(N_SIG), .N_OR(N_OR)) u_cell (
            .sig   (sig),
            .fuse  (map[p*PIN_BITS +: PIN_BITS]),
            .drive (drive[p]),
            .en    (en[p])
        );
    end

    // Loop-back value: own drive when enabled, external level otherwise.
    for (genvar j = 0; j < N_FB; j++) begin : g_fb
        assign fb_out[j] = en[FB_LO+j] ? drive[FB_LO+j] : fb_ext[j];
    end

endmodule

// File: rtl/fixed_or_array.sv
// Top of the fixed-OR programmable array. Holds the serial map and
// unrolls the loop-back path into settle_stages() passes so that any
// acyclic chain resolves without a structural combinational loop.
// Assumes: loaded maps are free of loops through the loop-back pins.
module fixed_or_array #(
    parameter int unsigned N_IN  = far_pkg::DEF_N_IN,
    parameter int unsigned N_PIN = far_pkg::DEF_N_PIN,
    parameter int unsigned N_OR  = far_pkg::DEF_N_OR,
    parameter int unsigned FB_LO = far_pkg::DEF_FB_LO,
    parameter int unsigned FB_HI = far_pkg::DEF_FB_HI
) (
    input  logic             cfg_clk,
    input  logic             cfg_rst_n,
    input  logic             cfg_load,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_PIN-1:0] pin_in,
    output logic [N_PIN-1:0] pin_out,
    output logic [N_PIN-1:0] pin_oe
);

    localparam int unsigned N_FB     = FB_HI - FB_LO + 1;
    localparam int unsigned N_SIG    = N_IN + N_FB;
    localparam int unsigned PIN_BITS = (N_OR + 1) * 2 * N_SIG;
    localparam int unsigned MAP_BITS = N_PIN * PIN_BITS;
    localparam int unsigned N_STAGE  = far_pkg::settle_stages(N_FB);
    localparam logic [N_PIN-1:0] FB_MASK = N_PIN'(((1 << N_FB) - 1) << FB_LO);

    logic [MAP_BITS-1:0] fuse_map;
    logic [N_FB-1:0]     fb_chain [N_STAGE+1];
    logic [N_PIN-1:0]    drv_st   [N_STAGE];
    logic [N_PIN-1:0]    en_st    [N_STAGE];
    logic                unused_pins;

    // Serial map storage.
    far_fuse_chain #(.MAP_BITS(MAP_BITS)) u_fuses (
        .clk      (cfg_clk),
        .rst_n    (cfg_rst_n),
        .shift_en (cfg_load),
        .din      (cfg_din),
        .map_q    (fuse_map)
    );

    // First pass assumes every loop-back pin shows its external level.
    assign fb_chain[0] = pin_in[FB_HI:FB_LO];

    // Unrolled evaluation passes; each refines the loop-back vector.
    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        far_stage #(
            .N_IN (N_IN),
            .N_PIN(N_PIN),
            .N_OR (N_OR),
            .FB_LO(FB_LO),
            .FB_HI(FB_HI)
        ) u_stage (
            .in_pins (in_pins),
            .fb_ext  (pin_in[FB_HI:FB_LO]),
            .fb_in   (fb_chain[s]),
            .map     (fuse_map),
            .drive   (drv_st[s]),
            .en      (en_st[s]),
            .fb_out  (fb_chain[s+1])
        );
    end

    // Pins take the settled pass; enables blanked during loading.
    assign pin_out = drv_st[N_STAGE-1];
    assign pin_oe  = cfg_load ? '0 : en_st[N_STAGE-1];

    // Pins without loop-back have no use for their external level.
    assign unused_pins = ^(pin_in & ~FB_MASK);

    // Enables must be off on every edge while loading.
    assert_oe_blank_loading_R9: assert property (
        @(posedge cfg_clk) disable iff (!cfg_rst_n)
        cfg_load |-> (pin_oe == '0)
    );

    // Map must not move while loading is idle.
    assert_map_hold_R8: assert property (
        @(posedge cfg_clk) disable iff (!cfg_rst_n)
        !cfg_load |=> $stable(fuse_map)
    );

    // Leaving reset: blank map, all pins released and high.
    assert_reset_blank_R10: assert property (
        @(posedge cfg_clk) disable iff (!cfg_rst_n)
        $past(!cfg_rst_n) |-> ((&fuse_map) && (pin_oe == '0) && (&pin_out))
    );

    // With a loaded acyclic map, the last two passes agree.
    assert_fb_settled_R11: assert property (
        @(posedge cfg_clk) disable iff (!cfg_rst_n)
        !cfg_load |-> (fb_chain[N_STAGE] == fb_chain[N_STAGE-1])
    );

endmodule

// File: tb/fixed_or_array_tb.sv
// Self-checking bench: loads several maps and sweeps every in_pins
// value against an arithmetic model built from the requirements.
module fixed_or_array_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NI   = 10;
    localparam int NP   = 8;
    localparam int NCOL = 32;
    localparam int MAP  = 2048;
    localparam int WD_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_load;
    logic       cfg_din;
    logic [9:0] in_pins;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    bit  fmap [MAP];
    logic [31:0] rs = 32'h2468ACE1;

    fixed_or_array u_dut (
        .cfg_clk   (clk),
        .cfg_rst_n (rst_n),
        .cfg_load  (cfg_load),
        .cfg_din   (cfg_din),
        .in_pins   (in_pins),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rnd();
        rs ^= rs << 13;
        rs ^= rs >> 17;
        rs ^= rs << 5;
        return rs;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (in=%h pin_in=%h)", req, act, exp, in_pins, pin_in);
        end
    endtask

    // Model of one term from the map layout of R7.
    function automatic bit m_term(input int p, input int t, input logic [15:0] s);
        bit r = 1'b1;
        int base = (p * 8 + t) * NCOL;
        for (int i = 0; i < 16; i++) begin
            if (fmap[base + 2*i] && !s[i]) r = 1'b0;
            if (fmap[base + 2*i + 1] && s[i]) r = 1'b0;
        end
        return r;
    endfunction

    // Model of all pins, iterating loop-back to a fixed point (R5, R11).
    function automatic void m_eval(input logic [9:0] iv, input logic [7:0] pv,
                                   output logic [7:0] o, output logic [7:0] e);
        logic [5:0] fb = pv[6:1];
        o = '0;
        e = '0;
        for (int it = 0; it < 9; it++) begin
            for (int p = 0; p < NP; p++) begin
                bit orv = 1'b0;
                for (int t = 0; t < 7; t++) orv |= m_term(p, t, {fb, iv});
                o[p] = ~orv;
                e[p] = m_term(p, 7, {fb, iv});
            end
            for (int j = 0; j < 6; j++) fb[j] = e[j+1] ? o[j+1] : pv[j+1];
        end
    endfunction

    task automatic fill(input bit v);
        for (int i = 0; i < MAP; i++) fmap[i] = v;
    endtask

    task automatic lit(input int p, input int t, input int s, input bit neg);
        fmap[(p * 8 + t) * NCOL + 2*s + (neg ? 1 : 0)] = 1'b1;
    endtask

    task automatic kill(input int p, input int t);
        lit(p, t, 0, 1'b0);
        lit(p, t, 0, 1'b1);
    endtask

    // Random map kept acyclic: pin k may only use loop-back of higher pins.
    task automatic rand_map(input int dens);
        fill(1'b0);
        for (int p = 0; p < NP; p++)
            for (int t = 0; t < 8; t++)
                for (int s = 0; s < 16; s++) begin
                    bit ok = (s < NI) || (p == 0) || (p == 7) || ((s - NI + 1) > p);
                    logic [31:0] r = rnd();
                    if (ok && (r % dens == 0)) lit(p, t, s, r[20]);
                end
    endtask

    // Shift the model map in, first bit = index 0 (R8); checks R9 on the way.
    task automatic load_map();
        for (int i = 0; i < MAP; i++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_din  = fmap[i];
            if (i == 0 || i == 4 || i == 1500) begin
                #1;
                chk("R9 enables blank while loading", {8'h0, pin_oe}, 16'h0);
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
    endtask

    // Sweep in_pins; mode 1 adds R2/R3 pin checks, mode 2 adds chain checks.
    task automatic sweep(input string tag, input int n, input int mode, input bit r6);
        logic [7:0] eo, ee, so, se;
        for (int i = 0; i < n; i++) begin
            logic [9:0] iv = i[9:0];
            logic [7:0] pv = 8'((i * 37) ^ (i >> 3) ^ n_chk);
            @(negedge clk);
            in_pins = iv;
            pin_in  = pv;
            #1;
            m_eval(iv, pv, eo, ee);
            chk(tag, {pin_out, pin_oe}, {eo, ee});
            if (mode == 1) begin
                chk("R2 empty terms drive pin 0 low", {15'h0, pin_out[0]}, 16'h0);
                chk("R3 contradictory terms drive pin 7 high", {15'h0, pin_out[7]}, 16'h1);
            end
            if (mode == 2) begin
                if (iv[1]) chk("R11 six-pin chain settles", {15'h0, pin_out[1]}, {15'h0, iv[0]});
                else       chk("R5 released pin feeds pin_in", {15'h0, pin_out[1]}, {15'h0, ~pv[6]});
            end
            if (r6) begin
                so = pin_out;
                se = pin_oe;
                pin_in = pv ^ 8'h81;
                #1;
                chk("R6 pin_in[0]/[7] ignored", {pin_out, pin_oe}, {so, se});
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
        in_pins  = '0;
        pin_in   = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: blank map after reset.
        fill(1'b1);
        sweep("R10 reset map", 64, 0, 1'b0);
        chk("R10 pins after reset", {pin_out, pin_oe}, 16'hFF00);

        // R1 R2 R4 R7: random maps of moderate density.
        rand_map(6);
        load_map();
        sweep("R1 R4 R7 random map A", 1024, 0, 1'b0);

        // R2 R3: directed empty and contradictory terms.
        rand_map(8);
        for (int t = 0; t < 8; t++)
            for (int c = 0; c < NCOL; c++) fmap[t * NCOL + c] = 1'b0;
        for (int t = 0; t < 7; t++) kill(7, t);
        for (int c = 0; c < NCOL; c++) fmap[(7 * 8 + 7) * NCOL + c] = 1'b0;
        load_map();
        sweep("R1 R2 R3 R4 directed map", 1024, 1, 1'b0);

        rand_map(10);
        load_map();
        sweep("R1 R4 R7 random map B", 1024, 0, 1'b1);

        // R5 R6 R11: loop-back chain pin6 -> pin5 -> ... -> pin1.
        fill(1'b0);
        for (int p = 0; p < NP; p++)
            for (int t = 1; t < 7; t++) kill(p, t);
        for (int k = 1; k <= 5; k++) lit(k, 0, NI + k, 1'b0);
        lit(6, 0, 0, 1'b0);
        lit(6, 7, 1, 1'b0);
        lit(0, 0, NI, 1'b1);
        lit(7, 0, NI + 5, 1'b0);
        lit(7, 0, 2, 1'b0);
        lit(7, 7, 3, 1'b1);
        load_map();
        sweep("R5 R11 chain map", 1024, 2, 1'b1);

        // R8: shifting data with cfg_load low must not change the map.
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            cfg_din = rnd() & 32'h1;
        end
        cfg_din = 1'b0;
        sweep("R8 map held while idle", 1024, 2, 1'b0);

        rand_map(4);
        load_map();
        sweep("R1 R2 R4 R7 dense map", 1024, 0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule